// File: doc/BRIEF.md
# Video Colour Bar Pattern Generator

This block sits in a display output path and can replace the upstream pixel stream with a test pattern that it builds itself, without any frame buffer or memory. When the block is switched on, it either draws eight vertical colour bars across each active line or fills the active area with one flat colour taken from the control words. The bars can be made to scroll: every N frames the whole bar set moves one bar position to the right and wraps around.

Pixel timing comes from one of two places, chosen by a single control bit. The block can follow the upstream stream's data-enable and vertical sync, or it can use a small internal raster counter whose active and blanking sizes are parameters. When the generator is off, the upstream pixels pass straight through, delayed by one register.

Software sets the block up through two 32-bit control words on a plain write port. The block does not use a written value straight away. It keeps the value pending and moves it into use only at the next frame start of the timing source in use, so a frame is never drawn with a mix of old and new settings.

Top module: `cbar_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs are cleared (`out_de` = 0, all colour channels 0), both control words are cleared to zero, the scroll offset and the frame counter are zero, and the internal raster counter returns to its origin.
- R2: When the control word in use has its enable bit (word 0, bit 0) clear, each output equals the matching input one clock earlier: `out_de` follows `in_de` and `out_r`/`out_g`/`out_b` follow `in_r`/`in_g`/`in_b`.
- R3: A write with `reg_we` high at address 0x260 loads control word 0, and one at address 0x264 loads control word 1. A write to any other address changes nothing. Word 0 holds: bit 0 enable, bits 8:1 scroll rate, bit 9 timing source (1 = internal), bit 10 pattern type (1 = solid), bits 23:12 red. Word 1 holds: bits 23:12 green, bits 11:0 blue.
- R4: A written word takes effect only on the clock edge at which a frame start occurs for the timing source selected by the settings in use before that edge. Until then, the output follows the old settings.
- R5: Internal timing scans `H_ACT+H_BLK` pixels per line and `V_ACT+V_BLK` lines per frame, starting at pixel 0, line 0, after reset. Data enable is high when pixel < `H_ACT` and line < `V_ACT`. A one-cycle frame start occurs at pixel 0 of line `V_ACT`.
- R6: External timing takes its frame start from a rising edge of `in_vsync` and its data enable from `in_de`. The horizontal position is the number of consecutive `in_de` cycles that came before it on the current line.
- R7: In bar mode, pixel position x falls in bar p = x / (`H_ACT`/8), limited to 7. The bar colours, by index, are: 0 white, 1 yellow, 2 cyan, 3 green, 4 magenta, 5 red, 6 blue, 7 black. A channel that is on in a colour is driven to 0xFFF and a channel that is off is driven to 0.
- R8: In solid mode, every enabled pixel shows the red value from word 0 bits 23:12, the green value from word 1 bits 23:12 and the blue value from word 1 bits 11:0.
- R9: With scroll offset k, bar position p shows colour (p − k) mod 8. At each frame start with the generator enabled and rate N ≠ 0, the frame counter advances. When it reaches N frames, it clears and k increments modulo 8. Otherwise the counter clears and k holds. The step uses the rate in use for the frame that is ending.
- R10: When the generator is enabled and the selected data enable is low, the next output has `out_de` = 0 and all channels 0.
- R11: When the generator is enabled, each output pixel is produced one clock after the timing position it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_addr | input | ADDR_W | Control word byte address |
| reg_wdata | input | 32 | Control word write data |
| in_de | input | 1 | Upstream data enable |
| in_vsync | input | 1 | Upstream vertical sync, active high |
| in_r | input | 12 | Upstream red |
| in_g | input | 12 | Upstream green |
| in_b | input | 12 | Upstream blue |
| out_de | output | 1 | Output data enable |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
The main function is tried with four kinds of input. Upstream frames with a counting pixel ramp, shown with the generator off, show that data passes through with exact one-cycle alignment. Static bars on external timing show that the bar width, bar order and position counter are correct. Scrolling at rates 2 and 1 over more than eight steps shows the right step spacing and the wrap of the offset. A solid colour with three different channel values shows that the word 0 and word 1 fields are not swapped. Control writes placed just before frame boundaries, writes to neighbouring addresses, and a switch to internal timing while upstream frames keep running show that new settings wait for the frame start of the timing source in use.

// File: rtl/cbar_pkg.sv
// Shared definitions for the colour bar generator.
// Assumes 12-bit channels and a fixed set of eight bars.
package cbar_pkg;

    localparam int CH_W      = 12;
    localparam int RATE_W    = 8;
    localparam int NUM_BARS  = 8;
    localparam int BAR_IDX_W = $clog2(NUM_BARS);
    localparam int REG_W     = 32;

    // Settings in use, decoded from the two control words
    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
        logic              self_tm;
        logic              solid;
        logic [CH_W-1:0]   red;
        logic [CH_W-1:0]   green;
        logic [CH_W-1:0]   blue;
    } cfg_t;

    // Channel-on mask {r,g,b} for a bar colour index
    function automatic logic [2:0] bar_mask(input logic [BAR_IDX_W-1:0] pos);
        case (pos)
            3'd0:    bar_mask = 3'b111;
            3'd1:    bar_mask = 3'b110;
            3'd2:    bar_mask = 3'b011;
            3'd3:    bar_mask = 3'b010;
            3'd4:    bar_mask = 3'b101;
            3'd5:    bar_mask = 3'b100;
            3'd6:    bar_mask = 3'b001;
            default: bar_mask = 3'b000;
        endcase
    endfunction

    // Split the two raw control words into fields
    function automatic cfg_t decode_cfg(input logic [REG_W-1:0] w0,
                                        input logic [REG_W-1:0] w1);
        cfg_t c;
        c.en      = w0[0];
        c.rate    = w0[8:1];
        c.self_tm = w0[9];
        c.solid   = w0[10];
        c.red     = w0[23:12];
        c.green   = w1[23:12];
        c.blue    = w1[11:0];
        return c;
    endfunction

endpackage

// File: rtl/cbar_regs.sv
// Control word storage with frame-aligned shadowing.
// Writes land in pending words; the settings in use load from them
// only on a frame start pulse. Assumes frame_start is one cycle wide.
module cbar_regs
    import cbar_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CTRL0_ADDR = 'h260,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 'h264
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              frame_start,
    output cfg_t              act_cfg
);

    logic [REG_W-1:0] pend0;
    logic [REG_W-1:0] pend1;
    logic             unused_bits;

    assign unused_bits = ^{pend0[31:24], pend0[11], pend1[31:24]};

    // Capture software writes into the pending words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend0 <= '0;
            pend1 <= '0;
        end else if (we) begin
            if (addr == CTRL0_ADDR) pend0 <= wdata;
            if (addr == CTRL1_ADDR) pend1 <= wdata;
        end
    end

    // Move pending words into use at frame start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
        end else if (frame_start) begin
            act_cfg <= decode_cfg(pend0, pend1);
        end
    end

endmodule

// File: rtl/cbar_timing.sv
// Free-running internal raster counter.
// Produces data enable over the active window and a one-cycle frame
// start at the first pixel of the vertical blank. Assumes H_BLK, V_BLK >= 1.
module cbar_timing #(
    parameter int H_ACT = 640,
    parameter int H_BLK = 160,
    parameter int V_ACT = 480,
    parameter int V_BLK = 45
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    output logic [$clog2(H_ACT+H_BLK+1)-1:0]     h_pos,
    output logic                                 de,
    output logic                                 frame_start
);

    localparam int H_TOT = H_ACT + H_BLK;
    localparam int V_TOT = V_ACT + V_BLK;
    localparam int X_W   = $clog2(H_TOT + 1);
    localparam int Y_W   = $clog2(V_TOT + 1);

    logic [Y_W-1:0] v_pos;

    // Advance pixel and line counters, wrapping at the totals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (h_pos == X_W'(H_TOT - 1)) begin
            h_pos <= '0;
            v_pos <= (v_pos == Y_W'(V_TOT - 1)) ? '0 : v_pos + 1'b1;
        end else begin
            h_pos <= h_pos + 1'b1;
        end
    end

    // Decode the active window and the frame start point
    always_comb begin
        de          = (h_pos < X_W'(H_ACT)) && (v_pos < Y_W'(V_ACT));
        frame_start = (h_pos == '0) && (v_pos == Y_W'(V_ACT));
    end

endmodule

// File: rtl/cbar_motion.sv
// Scroll control: counts frame starts and steps the bar offset
// once every `rate` frames. A rate of zero, or a disabled generator,
// holds the offset and clears the frame count.
module cbar_motion
    import cbar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 en,
    input  logic [RATE_W-1:0]    rate,
    output logic [BAR_IDX_W-1:0] offset
);

    logic [RATE_W-1:0] fcnt;

    // Step frame counter and offset at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt   <= '0;
            offset <= '0;
        end else if (frame_start) begin
            if (en && (rate != '0)) begin
                if (fcnt >= rate - 1'b1) begin
                    fcnt   <= '0;
                    offset <= offset + 1'b1;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end else begin
                fcnt <= '0;
            end
        end
    end

endmodule

// File: rtl/cbar_pixel.sv
// Output stage: picks the pass-through pixel, a solid colour or a bar
// colour, and registers it. Assumes BAR_W >= 1.
module cbar_pixel
    import cbar_pkg::*;
#(
    parameter int X_W   = 10,
    parameter int BAR_W = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cfg_t                 cfg,
    input  logic [BAR_IDX_W-1:0] offset,
    input  logic                 src_de,
    input  logic [X_W-1:0]       x,
    input  logic                 in_de,
    input  logic [CH_W-1:0]      in_r,
    input  logic [CH_W-1:0]      in_g,
    input  logic [CH_W-1:0]      in_b,
    output logic                 out_de,
    output logic [CH_W-1:0]      out_r,
    output logic [CH_W-1:0]      out_g,
    output logic [CH_W-1:0]      out_b
);

    localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

    logic [X_W-1:0]       bar_raw;
    logic [BAR_IDX_W-1:0] bar_pos;
    logic [2:0]           mask;
    logic                 nx_de;
    logic [CH_W-1:0]      nx_r, nx_g, nx_b;

    // Locate the bar under x and rotate it by the scroll offset
    always_comb begin
        bar_raw = x / X_W'(BAR_W);
        bar_pos = (bar_raw >= X_W'(NUM_BARS)) ? BAR_IDX_W'(NUM_BARS - 1)
                                              : bar_raw[BAR_IDX_W-1:0];
        mask    = bar_mask(bar_pos - offset);
    end

    // Choose the next pixel from the active source
    always_comb begin
        if (!cfg.en) begin
            nx_de = in_de;
            nx_r  = in_r;
            nx_g  = in_g;
            nx_b  = in_b;
        end else if (!src_de) begin
            nx_de = 1'b0;
            nx_r  = '0;
            nx_g  = '0;
            nx_b  = '0;
        end else if (cfg.solid) begin
            nx_de = 1'b1;
            nx_r  = cfg.red;
            nx_g  = cfg.green;
            nx_b  = cfg.blue;
        end else begin
            nx_de = 1'b1;
            nx_r  = mask[2] ? FULL : '0;
            nx_g  = mask[1] ? FULL : '0;
            nx_b  = mask[0] ? FULL : '0;
        end
    end

    // Register the chosen pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_de <= 1'b0;
            out_r  <= '0;
            out_g  <= '0;
            out_b  <= '0;
        end else begin
            out_de <= nx_de;
            out_r  <= nx_r;
            out_g  <= nx_g;
            out_b  <= nx_b;
        end
    end

endmodule

// File: rtl/cbar_gen.sv
// Colour bar generator top. Joins the control words, the internal
// timing, the external timing tracking, the scroll control and the
// output stage. The timing source in use decides which frame start
// loads new settings and steps the scroll. Assumes H_ACT >= 8.
module cbar_gen
    import cbar_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CTRL0_ADDR = 'h260,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 'h264,
    parameter int                H_ACT      = 640,
    parameter int                H_BLK      = 160,
    parameter int                V_ACT      = 480,
    parameter int                V_BLK      = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_de,
    input  logic              in_vsync,
    input  logic [11:0]       in_r,
    input  logic [11:0]       in_g,
    input  logic [11:0]       in_b,
    output logic              out_de,
    output logic [11:0]       out_r,
    output logic [11:0]       out_g,
    output logic [11:0]       out_b
);

    localparam int X_W   = $clog2(H_ACT + H_BLK + 1);
    localparam int BAR_W = H_ACT / NUM_BARS;

    cfg_t                 act_cfg;
    logic [X_W-1:0]       int_x;
    logic                 int_de;
    logic                 int_fs;
    logic [X_W-1:0]       ext_x;
    logic                 vs_q;
    logic                 ext_fs;
    logic                 frame_start;
    logic                 src_de;
    logic [X_W-1:0]       src_x;
    logic [BAR_IDX_W-1:0] offset;

    cbar_regs #(
        .ADDR_W     (ADDR_W),
        .CTRL0_ADDR (CTRL0_ADDR),
        .CTRL1_ADDR (CTRL1_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .frame_start (frame_start),
        .act_cfg     (act_cfg)
    );

    cbar_timing #(
        .H_ACT (H_ACT),
        .H_BLK (H_BLK),
        .V_ACT (V_ACT),
        .V_BLK (V_BLK)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_pos       (int_x),
        .de          (int_de),
        .frame_start (int_fs)
    );

    // Track upstream line position and the previous vsync level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_x <= '0;
            vs_q  <= 1'b0;
        end else begin
            vs_q <= in_vsync;
            if (!in_de)                     ext_x <= '0;
            else if (ext_x != {X_W{1'b1}})  ext_x <= ext_x + 1'b1;
        end
    end

    // Select timing source signals according to the settings in use
    always_comb begin
        ext_fs      = in_vsync && !vs_q;
        frame_start = act_cfg.self_tm ? int_fs : ext_fs;
        src_de      = act_cfg.self_tm ? int_de : in_de;
        src_x       = act_cfg.self_tm ? int_x  : ext_x;
    end

    cbar_motion u_motion (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .en          (act_cfg.en),
        .rate        (act_cfg.rate),
        .offset      (offset)
    );

    cbar_pixel #(
        .X_W   (X_W),
        .BAR_W (BAR_W)
    ) u_pixel (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (act_cfg),
        .offset (offset),
        .src_de (src_de),
        .x      (src_x),
        .in_de  (in_de),
        .in_r   (in_r),
        .in_g   (in_g),
        .in_b   (in_b),
        .out_de (out_de),
        .out_r  (out_r),
        .out_g  (out_g),
        .out_b  (out_b)
    );

endmodule

// File: rtl/cbar_gen_chk.sv
// Property checker for cbar_gen, attached with bind below.
module cbar_gen_chk
    import cbar_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_de,
    input logic [CH_W-1:0]      in_r,
    input logic [CH_W-1:0]      in_b,
    input logic                 out_de,
    input logic [CH_W-1:0]      out_r,
    input logic [CH_W-1:0]      out_g,
    input logic [CH_W-1:0]      out_b,
    input cfg_t                 act_cfg,
    input logic                 frame_start,
    input logic                 int_fs,
    input logic                 src_de,
    input logic [BAR_IDX_W-1:0] offset
);

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.en |=> (out_de == $past(in_de)) && (out_r == $past(in_r))
                        && (out_b == $past(in_b)));

    // R10
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.en && !src_de) |=> !out_de && (out_r == '0) && (out_g == '0)
                                    && (out_b == '0));

    // R8
    solid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.en && act_cfg.solid && src_de) |=> out_de
            && (out_r == $past(act_cfg.red)) && (out_g == $past(act_cfg.green))
            && (out_b == $past(act_cfg.blue)));

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_cfg));

    // R9
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(offset));

    // R5
    int_fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_fs |=> !int_fs);

endmodule

bind cbar_gen cbar_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_de       (in_de),
    .in_r        (in_r),
    .in_b        (in_b),
    .out_de      (out_de),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b),
    .act_cfg     (act_cfg),
    .frame_start (frame_start),
    .int_fs      (int_fs),
    .src_de      (src_de),
    .offset      (offset)
);

// File: tb/cbar_gen_tb.sv
// Scoreboard bench: a reference model predicts each output cycle from
// the requirements and queues it; the monitor compares one cycle later.
module cbar_gen_tb;

    localparam int HA = 16, HB = 4, VA = 4, VB = 2;
    localparam int HT = HA + HB, VT = VA + VB, BW = HA / 8;

    typedef struct {
        logic        de;
        logic [11:0] r, g, b;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_de = 1'b0, in_vsync = 1'b0;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic        out_de;
    logic [11:0] out_r, out_g, out_b;

    int    checks = 0, errors = 0;
    bit    finished = 1'b0;
    string phase = "R1";
    item_t sb_q[$];

    // reference model state
    logic [31:0] m_pend0 = '0, m_pend1 = '0, m_act0 = '0, m_act1 = '0;
    int          m_off = 0, m_fcnt = 0, m_h = 0, m_v = 0, m_x = 0;
    logic        m_vsq = 1'b0;
    logic [11:0] pix = '0;

    cbar_gen #(.H_ACT(HA), .H_BLK(HB), .V_ACT(VA), .V_BLK(VB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_de(in_de), .in_vsync(in_vsync),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_de(out_de),
        .out_r(out_r), .out_g(out_g), .out_b(out_b));

    always #10 clk = ~clk;

    // R7 palette: index -> {r,g,b} on-mask
    function automatic logic [2:0] ref_mask(input int c);
        case (c)
            0: return 3'b111; 1: return 3'b110; 2: return 3'b011;
            3: return 3'b010; 4: return 3'b101; 5: return 3'b100;
            6: return 3'b001; default: return 3'b000;
        endcase
    endfunction

    // R3 field packing of control word 0
    function automatic logic [31:0] w0(input logic en, input logic [7:0] rate,
                                       input logic self_tm, input logic solid,
                                       input logic [11:0] red);
        return {8'd0, red, 1'b0, solid, self_tm, rate, en};
    endfunction

    // Monitor: pop the oldest prediction and compare with the outputs
    task automatic monitor_cmp();
        item_t e;
        if (sb_q.size() == 0) return;
        e = sb_q.pop_front();
        checks++;
        if (out_de !== e.de || out_r !== e.r || out_g !== e.g || out_b !== e.b) begin
            errors++;
            $display("FAIL %s: got de=%0b rgb=%h/%h/%h expected de=%0b rgb=%h/%h/%h",
                     e.tag, out_de, out_r, out_g, out_b, e.de, e.r, e.g, e.b);
        end
    endtask

    // Driver side of the scoreboard: predict the next output and step model
    task automatic predict();
        item_t e;
        logic a_en, a_sel, a_sol, int_de, fs, sde, ok_wr;
        int   a_rate, xpos, idx;
        logic [2:0] mk;
        if (!rst_n) begin   // R1
            e.de = 0; e.r = 0; e.g = 0; e.b = 0; e.tag = {phase, "/R1"};
            sb_q.push_back(e);
            m_pend0 = 0; m_pend1 = 0; m_act0 = 0; m_act1 = 0;
            m_off = 0; m_fcnt = 0; m_h = 0; m_v = 0; m_x = 0; m_vsq = 0;
            return;
        end
        a_en = m_act0[0]; a_rate = int'(m_act0[8:1]);
        a_sel = m_act0[9]; a_sol = m_act0[10];
        int_de = (m_h < HA) && (m_v < VA);                          // R5
        fs = a_sel ? (m_h == 0 && m_v == VA) : (in_vsync && !m_vsq); // R5 R6
        sde = a_sel ? int_de : in_de;
        xpos = a_sel ? m_h : m_x;
        if (!a_en) begin                                             // R2
            e.de = in_de; e.r = in_r; e.g = in_g; e.b = in_b; e.tag = {phase, "/R2"};
        end else if (!sde) begin                                     // R10
            e.de = 0; e.r = 0; e.g = 0; e.b = 0; e.tag = {phase, "/R10"};
        end else if (a_sol) begin                                    // R8
            e.de = 1; e.r = m_act0[23:12]; e.g = m_act1[23:12]; e.b = m_act1[11:0];
            e.tag = {phase, "/R8"};
        end else begin                                               // R7 R9 R11
            idx = xpos / BW; if (idx > 7) idx = 7;
            mk = ref_mask((idx + 8 - m_off) % 8);
            e.de = 1; e.r = mk[2] ? 12'hFFF : 12'h0;
            e.g = mk[1] ? 12'hFFF : 12'h0; e.b = mk[0] ? 12'hFFF : 12'h0;
            e.tag = (m_off != 0) ? {phase, "/R9"} : {phase, "/R7"};
        end
        sb_q.push_back(e);
        // state update as of the coming edge
        if (fs) begin                                                // R4 R9
            if (a_en && a_rate != 0) begin
                if (m_fcnt >= a_rate - 1) begin m_fcnt = 0; m_off = (m_off + 1) % 8; end
                else m_fcnt++;
            end else m_fcnt = 0;
            m_act0 = m_pend0; m_act1 = m_pend1;
        end
        ok_wr = reg_we;                                              // R3
        if (ok_wr && reg_addr == 12'h260) m_pend0 = reg_wdata;
        if (ok_wr && reg_addr == 12'h264) m_pend1 = reg_wdata;
        m_h++; if (m_h == HT) begin m_h = 0; m_v = (m_v + 1) % VT; end
        m_x = in_de ? m_x + 1 : 0;
        m_vsq = in_vsync;
    endtask

    always @(negedge clk) begin
        monitor_cmp();
        predict();
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_de = 0; in_vsync = 0; in_r = 0; in_g = 0; in_b = 0; tick();
        end
    endtask

    task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; in_de = 0; in_vsync = 0;
        tick();
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    // Upstream frames: vsync pulse, a gap, then VA lines of HA pixels
    task automatic ext_frames(input int n);
        for (int f = 0; f < n; f++) begin
            for (int i = 0; i < 2; i++) begin in_vsync = 1; in_de = 0; tick(); end
            in_vsync = 0; tick();
            for (int l = 0; l < VA; l++) begin
                for (int p = 0; p < HA; p++) begin
                    pix = pix + 12'd37;
                    in_de = 1; in_r = pix; in_g = ~pix; in_b = pix ^ 12'h5A5; tick();
                end
                for (int p = 0; p < HB; p++) begin
                    in_de = 0; in_r = 0; in_g = 0; in_b = 0; tick();
                end
            end
        end
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        phase = "R1"; rst_n = 0;
        tick(); tick(); tick();
        rst_n = 1;
        phase = "R2"; ext_frames(2);
        phase = "R3";                         // ignored addresses
        write_reg(12'h268, w0(1, 8'd0, 0, 1, 12'hABC));
        write_reg(12'h25C, 32'hFFFF_FFFF);
        ext_frames(1);
        phase = "R4";                         // enable bars on external timing
        write_reg(12'h260, w0(1, 8'd0, 0, 0, 12'h0));
        ext_frames(1);
        phase = "R6"; ext_frames(2);
        phase = "R9 rate2";
        write_reg(12'h260, w0(1, 8'd2, 0, 0, 12'h0));
        ext_frames(5);
        phase = "R9 wrap";
        write_reg(12'h260, w0(1, 8'd1, 0, 0, 12'h0));
        ext_frames(10);
        phase = "R8";
        write_reg(12'h264, {8'd0, 12'h123, 12'h800});
        write_reg(12'h260, w0(1, 8'd0, 0, 1, 12'hABC));
        ext_frames(2);
        phase = "R5";                         // switch to internal timing
        write_reg(12'h260, w0(1, 8'd0, 1, 0, 12'h0));
        ext_frames(1);
        idle(3 * HT * VT);
        phase = "R5 ext ignored"; ext_frames(1);
        phase = "R2 disable";
        write_reg(12'h260, w0(0, 8'd0, 1, 0, 12'h0));
        idle(HT * VT + 5);
        ext_frames(1);
        idle(3);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule